// File: doc/BRIEF.md
# FPU Register High-Half Transfer

This block moves the upper 32-bit half of a floating-point register to or from the integer side. It holds a small floating-point register file of 32 entries of 64 bits each. One request per cycle comes in: a direction (toward the integer side or toward the floating-point side), a register index, a 64-bit integer operand and a mode bit. The mode bit selects between two register layouts. In wide mode every floating-point register is 64 bits and its high half is bits 63:32. In paired mode each register is treated as 32 bits wide. A 64-bit value then spans an even/odd pair, and its high half is the low word of the odd partner.

Naming an odd register in paired mode is a programming error. The block still completes the request. A read returns a fixed poison word, sign-extended. A write stores a different fixed poison word into the low half of the named register. In both cases a misuse flag is raised for one cycle. Integer results are registered and stay unchanged until the next read toward the integer side. A combinational read port on the register file lets the floating-point datapath see whole registers.

Top module: `hihalf_xfer`

## Requirements
- R1: A synchronous active-high reset clears all 32 floating-point registers to zero and drives `gpr_out` and `misuse` to zero.
- R2: In wide mode (`req_wide`=1), a read toward the integer side (`req_dir`=0) sets `gpr_out`, on the next clock edge, to bits 63:32 of register `req_idx`, sign-extended to 64 bits.
- R3: In wide mode, a write toward the floating-point side (`req_dir`=1) stores `gpr_in[31:0]` into bits 63:32 of register `req_idx`. Bits 31:0 keep their value.
- R4: In paired mode (`req_wide`=0) with an even index, a read sets `gpr_out` to bits 31:0 of register `req_idx`+1, sign-extended.
- R5: In paired mode with an even index, a write stores `gpr_in[31:0]` into bits 31:0 of register `req_idx`+1. Its bits 63:32 and register `req_idx` are unchanged.
- R6: In paired mode with an odd index, a read sets `gpr_out` to the poison word 0x0BADF00D, sign-extended (0x000000000BADF00D).
- R7: In paired mode with an odd index, a write stores 0xDEADC0DE into bits 31:0 of register `req_idx` and keeps its bits 63:32. `gpr_in` has no effect.
- R8: `misuse` is high for exactly the one cycle after each accepted paired-mode, odd-index request, and low otherwise.
- R9: `gpr_out` holds its value across cycles with no request (`req_valid`=0) and across write requests.
- R10: `fpr_rd_data` shows the whole register `fpr_rd_idx` combinationally. A write becomes visible there after the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_dir | input | 1 | 0: floating-point to integer, 1: integer to floating-point |
| req_idx | input | 5 | Floating-point register index |
| req_wide | input | 1 | 1: 64-bit register mode, 0: paired 32-bit mode |
| gpr_in | input | 64 | Integer operand; only bits 31:0 are written |
| gpr_out | output | 64 | Registered sign-extended integer result |
| misuse | output | 1 | One-cycle flag for an odd index in paired mode |
| fpr_rd_idx | input | 5 | Register file read index for the floating-point side |
| fpr_rd_data | output | 64 | Register file read data |

## Verification
Some properties are checked by assertions on every cycle. `gpr_out` is always a sign extension of its low word. `misuse` rises only after an odd paired request and falls when none follows. A poison read always returns the fixed constant. Every half-write changes only the addressed half and leaves the other half alone. The bench's scenarios cover what needs a reference model across many requests. That includes the mapping of an even paired index to its odd partner, sign handling for negative and positive words, index 30 pairing with 31, `gpr_out` holding across idle and write cycles, and full register-file contents after a random mix of modes and directions.

// File: rtl/hihalf_pkg.sv
package hihalf_pkg;

    localparam int DATA_W   = 64;
    localparam int HALF_W   = DATA_W / 2;
    localparam int NUM_REGS = 32;
    localparam int IDX_W    = $clog2(NUM_REGS);

    localparam logic [HALF_W-1:0] POISON_RD = 32'h0BAD_F00D;
    localparam logic [HALF_W-1:0] POISON_WR = 32'hDEAD_C0DE;

    typedef enum logic { XDIR_TO_INT = 1'b0, XDIR_TO_FPR = 1'b1 } xdir_e;
    typedef enum logic { HALF_LO = 1'b0, HALF_HI = 1'b1 } half_e;

    typedef struct packed {
        xdir_e              dir;
        logic               wide;
        logic [IDX_W-1:0]   idx;
        logic [DATA_W-1:0]  opnd;
    } xfer_req_t;

    typedef struct packed {
        logic               en;
        logic [IDX_W-1:0]   idx;
        half_e              half;
        logic [HALF_W-1:0]  data;
    } half_wr_t;

    function automatic logic [DATA_W-1:0] sext_half(input logic [HALF_W-1:0] w);
        return {{(DATA_W-HALF_W){w[HALF_W-1]}}, w};
    endfunction

endpackage

// File: rtl/fpr_file.sv
module fpr_file
    import hihalf_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  half_wr_t            wr,
    input  logic [IDX_W-1:0]    ra_idx,
    output logic [DATA_W-1:0]   ra_data,
    input  logic [IDX_W-1:0]    rb_idx,
    output logic [DATA_W-1:0]   rb_data
);

    logic [DATA_W-1:0] ent_q [NUM_REGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++) ent_q[i] <= '0;
        end else if (wr.en) begin
            if (wr.half == HALF_HI) ent_q[wr.idx][DATA_W-1:HALF_W] <= wr.data;
            else                    ent_q[wr.idx][HALF_W-1:0]      <= wr.data;
        end
    end

    assign ra_data = ent_q[ra_idx];
    assign rb_data = ent_q[rb_idx];

    // R3 R5 R7: a half write leaves the other half of the entry untouched
    assert_hi_write_keeps_lo_R3: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.half == HALF_HI) |=>
            ent_q[$past(wr.idx)][HALF_W-1:0] == $past(ent_q[wr.idx][HALF_W-1:0]));
    assert_lo_write_keeps_hi_R5: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.half == HALF_LO) |=>
            ent_q[$past(wr.idx)][DATA_W-1:HALF_W] == $past(ent_q[wr.idx][DATA_W-1:HALF_W]));
    // R10: the written half holds the written word after the edge
    assert_write_lands_R10: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.half == HALF_LO) |=>
            ent_q[$past(wr.idx)][HALF_W-1:0] == $past(wr.data));

endmodule

// File: rtl/xfer_decode.sv
module xfer_decode
    import hihalf_pkg::*;
(
    input  logic                valid,
    input  xfer_req_t           req,
    output logic [IDX_W-1:0]    rd_idx,
    input  logic [DATA_W-1:0]   rd_data,
    output half_wr_t            wr,
    output logic                res_en,
    output logic [DATA_W-1:0]   res_val,
    output logic                bad_idx
);

    logic odd_paired;
    logic [IDX_W-1:0] partner;

    assign odd_paired = !req.wide && req.idx[0];
    assign partner    = req.idx | IDX_W'(1);

    always_comb begin
        rd_idx  = req.wide ? req.idx : partner;
        bad_idx = valid && odd_paired;

        res_en  = valid && (req.dir == XDIR_TO_INT);
        if (req.wide)       res_val = sext_half(rd_data[DATA_W-1:HALF_W]);
        else if (odd_paired) res_val = sext_half(POISON_RD);
        else                res_val = sext_half(rd_data[HALF_W-1:0]);

        wr.en = valid && (req.dir == XDIR_TO_FPR);
        if (req.wide) begin
            wr.idx  = req.idx;
            wr.half = HALF_HI;
            wr.data = req.opnd[HALF_W-1:0];
        end else if (odd_paired) begin
            wr.idx  = req.idx;
            wr.half = HALF_LO;
            wr.data = POISON_WR;
        end else begin
            wr.idx  = partner;
            wr.half = HALF_LO;
            wr.data = req.opnd[HALF_W-1:0];
        end
    end

endmodule

// File: rtl/hihalf_xfer.sv
module hihalf_xfer
    import hihalf_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                req_dir,
    input  logic [4:0]          req_idx,
    input  logic                req_wide,
    input  logic [63:0]         gpr_in,
    output logic [63:0]         gpr_out,
    output logic                misuse,
    input  logic [4:0]          fpr_rd_idx,
    output logic [63:0]         fpr_rd_data
);

    xfer_req_t          req;
    half_wr_t           wr;
    logic               acc;
    logic [IDX_W-1:0]   rd_idx;
    logic [DATA_W-1:0]  rd_data;
    logic               res_en;
    logic [DATA_W-1:0]  res_val;
    logic               bad_idx;

    assign acc = req_valid && !rst;
    assign req = '{dir: xdir_e'(req_dir), wide: req_wide, idx: req_idx, opnd: gpr_in};

    xfer_decode u_dec (
        .valid   (acc),
        .req     (req),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .wr      (wr),
        .res_en  (res_en),
        .res_val (res_val),
        .bad_idx (bad_idx)
    );

    fpr_file u_rf (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .ra_idx  (rd_idx),
        .ra_data (rd_data),
        .rb_idx  (fpr_rd_idx),
        .rb_data (fpr_rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            gpr_out <= '0;
            misuse  <= 1'b0;
        end else begin
            if (res_en) gpr_out <= res_val;
            misuse <= bad_idx;
        end
    end

    // R2 R4 R6: the integer result is always a sign-extended word
    assert_out_sext_R2: assert property (@(posedge clk) disable iff (rst)
        gpr_out[63:32] == {32{gpr_out[31]}});
    // R6: odd paired read returns the fixed poison value
    assert_poison_read_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_dir && !req_wide && req_idx[0]) |=> gpr_out == 64'h0000_0000_0BAD_F00D);
    // R8: flag only follows an odd paired request
    assert_misuse_cause_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_wide && req_idx[0]) |=> misuse);
    assert_misuse_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !req_wide && req_idx[0]) |=> !misuse);
    // R9: no read request leaves the result unchanged
    assert_out_holds_R9: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !req_dir) |=> $stable(gpr_out));

endmodule

// File: tb/sim_hihalf_xfer.sv
module sim_hihalf_xfer;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_dir = 1'b0;
    logic [4:0]  req_idx = '0;
    logic        req_wide = 1'b0;
    logic [63:0] gpr_in = '0;
    logic [63:0] gpr_out;
    logic        misuse;
    logic [4:0]  fpr_rd_idx = '0;
    logic [63:0] fpr_rd_data;

    int n_cmp = 0;
    int n_bad = 0;
    logic [63:0] m_fpr [32];
    logic [63:0] m_out;
    logic        m_mis;

    always #(CLK_P/2) clk = ~clk;

    hihalf_xfer u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_dir(req_dir),
        .req_idx(req_idx), .req_wide(req_wide), .gpr_in(gpr_in),
        .gpr_out(gpr_out), .misuse(misuse),
        .fpr_rd_idx(fpr_rd_idx), .fpr_rd_data(fpr_rd_data)
    );

    function automatic logic [63:0] sx(input logic [31:0] w);
        return {{32{w[31]}}, w};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model(input logic v, input logic d, input logic [4:0] ix,
                         input logic w, input logic [63:0] op);
        m_mis = v && !w && ix[0];
        if (!v) return;
        if (!d) begin
            if (w)          m_out = sx(m_fpr[ix][63:32]);
            else if (ix[0]) m_out = 64'h0000_0000_0BAD_F00D;
            else            m_out = sx(m_fpr[ix + 5'd1][31:0]);
        end else begin
            if (w)          m_fpr[ix][63:32] = op[31:0];
            else if (ix[0]) m_fpr[ix][31:0] = 32'hDEAD_C0DE;
            else            m_fpr[ix + 5'd1][31:0] = op[31:0];
        end
    endtask

    task automatic peek(input string tag, input logic [4:0] ix);
        fpr_rd_idx = ix;
        #1;
        chk(tag, fpr_rd_data, m_fpr[ix]);
    endtask

    // drive at negedge, check just after the next posedge
    task automatic op(input string tag, input logic v, input logic d, input logic [4:0] ix,
                      input logic w, input logic [63:0] val);
        @(negedge clk);
        req_valid = v; req_dir = d; req_idx = ix; req_wide = w; gpr_in = val;
        @(posedge clk);
        #1;
        model(v, d, ix, w, val);
        chk({tag, " gpr_out"}, gpr_out, m_out);
        chk({tag, " misuse R8"}, {63'd0, misuse}, {63'd0, m_mis});
        if (v && d) peek({tag, " fpr"}, (!w && !ix[0]) ? ix + 5'd1 : ix);
        req_valid = 1'b0;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) m_fpr[i] = '0;
        m_out = '0; m_mis = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        chk("R1 gpr_out reset", gpr_out, 64'd0);
        chk("R1 misuse reset", {63'd0, misuse}, 64'd0);
        for (int i = 0; i < 32; i++) peek("R1 fpr reset", 5'(i));

        // directed corners
        op("R3 wide write", 1, 1, 5'd5, 1, 64'h1111_2222_CAFE_BABE);
        op("R2 wide read neg", 1, 0, 5'd5, 1, 64'd0);
        chk("R2 value", gpr_out, 64'hFFFF_FFFF_CAFE_BABE);
        op("R5 paired write", 1, 1, 5'd4, 0, 64'hFFFF_0000_1234_5678);
        peek("R5 even reg untouched", 5'd4);
        op("R4 paired read", 1, 0, 5'd4, 0, 64'd0);
        chk("R4 value", gpr_out, 64'h0000_0000_1234_5678);
        op("R9 idle", 0, 0, 5'd0, 0, 64'd0);
        chk("R9 hold idle", gpr_out, 64'h0000_0000_1234_5678);
        op("R3 wide write keeps lo", 1, 1, 5'd5, 1, 64'h0000_0000_8765_4321);
        chk("R9 hold on write", gpr_out, 64'h0000_0000_1234_5678);
        op("R7 poison write", 1, 1, 5'd7, 0, 64'h0000_0000_0000_0001);
        chk("R7 value", fpr_rd_data, {32'd0, 32'hDEAD_C0DE});
        op("R6 poison read", 1, 0, 5'd3, 0, 64'd0);
        chk("R6 value", gpr_out, 64'h0000_0000_0BAD_F00D);
        op("R8 flag drops", 0, 0, 5'd3, 0, 64'd0);
        op("R5 index 30 pair", 1, 1, 5'd30, 0, 64'h0000_0000_8000_0001);
        op("R4 index 30 read", 1, 0, 5'd30, 0, 64'd0);
        chk("R4 idx30 value", gpr_out, 64'hFFFF_FFFF_8000_0001);
        op("R2 wide read reg31", 1, 0, 5'd31, 1, 64'd0);

        // constrained random mix, fixed seed
        void'($urandom(32'd4242));
        for (int k = 0; k < 600; k++) begin
            logic [3:0] r;
            r = 4'($urandom);
            op("R10 random", r != 4'd0, r[1], 5'($urandom), r[2],
               {$urandom, $urandom});
        end
        for (int i = 0; i < 32; i++) peek("R10 final sweep", 5'(i));

        // reset again mid-run
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        for (int i = 0; i < 32; i++) m_fpr[i] = '0;
        @(negedge clk); rst = 1'b0;
        #1;
        chk("R1 gpr_out re-reset", gpr_out, 64'd0);
        peek("R1 fpr re-reset", 5'd5);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule